// File: doc/BRIEF.md
# Three-Wire Serial Byte Shifter

This block moves a single byte across a bit-banged three-wire link. On the other end is a small clock chip whose registers are four bits wide. The host gives the block a byte, picks a direction and pulses a start strobe. The shifter then toggles the serial clock, which idles high. In transmit it drives the data line, and in receive it samples the data line. When the byte is finished it pulses done.

The data line is bidirectional. The block sets the line's value and its output enable separately. In transmit, the first bit is put on the line one cycle before the enable turns on, so the target never sees a glitch. The enable is released as soon as the byte ends. In receive, the block never drives the line. It samples once near the end of each high phase, just before the clock falls. Only the low nibble of the captured byte is returned.

Each clock phase lasts a parameterised number of system cycles. The default is about 700 ns at 125 MHz. Chip-enable control and command framing are handled by the logic around this block.

Top module: `tws_shifter`

## Requirements
- R1: A transmit puts exactly 8 bits on `sda_o`, most significant bit first. Bit k (k=0 for bit 7) is the value present at the k-th falling edge of `scl_o`.
- R2: `scl_o` is high whenever the block is idle, including after reset.
- R3: Within a byte, every low phase of `scl_o` lasts HALF_CYCLES clocks. So does every high phase between two falling edges.
- R4: In transmit, `sda_oe_o` is low in the cycle the first bit is placed on `sda_o`. It rises one cycle later with `sda_o` unchanged, and it stays high at every falling edge of the byte.
- R5: In receive, `sda_oe_o` stays low for the whole byte.
- R6: In the cycle `done_o` is high, `sda_oe_o` is low and `scl_o` is high.
- R7: In receive, `sda_i` is sampled during each high phase before the falling edge, most significant bit first. `rx_byte_o` then holds the low nibble of the byte, with bits 7:4 equal to zero.
- R8: `done_o` is high for exactly one cycle per byte.
- R9: A start strobe that arrives while `busy_o` is high has no effect: the byte in flight is unchanged and no extra byte follows.
- R10: `busy_o` is high in the cycle after an accepted start and drops when `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start one byte (accepted only when idle) |
| dir_rx_i | input | 1 | 1 = receive, 0 = transmit |
| tx_byte_i | input | 8 | Byte to transmit |
| sda_i | input | 1 | Data line as seen at the pad |
| busy_o | output | 1 | Byte in progress |
| done_o | output | 1 | One-cycle pulse at byte end |
| rx_byte_o | output | 8 | Received byte, low nibble only |
| scl_o | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Data line drive value |
| sda_oe_o | output | 1 | Data line output enable |

## Verification
On every cycle, assertions check four things: the idle-high clock, the ordering of data before enable, the fact that receive never drives the line, and the released line and one-cycle shape of done. They also check that busy rises after a start. The bench's scenarios are needed for the rest. Those are the MSB-first bit order, phase lengths measured edge to edge, and masked receive data from a target model that changes `sda_i` after each rising edge. The last is a start strobe injected in mid-byte, after which the bench confirms that the transfer in flight is intact and that no further byte follows.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_HIGH,
    ST_LOW,
    ST_END
  } tws_state_e;
endpackage

// File: rtl/tws_half_timer.sv
module tws_half_timer #(
  parameter int HALF_CYCLES = 88
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tws_shift_reg.sv
module tws_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], shift_in};
  end
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter #(
  parameter int HALF_CYCLES = 88,
  parameter int W           = 8,
  parameter int KEEP_W      = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         dir_rx_i,
  input  logic [W-1:0] tx_byte_i,
  input  logic         sda_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] rx_byte_o,
  output logic         scl_o,
  output logic         sda_o,
  output logic         sda_oe_o
);
  import tws_pkg::*;

  localparam int BCW = $clog2(W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(W - 1);

  tws_state_e     state;
  logic [BCW-1:0] bit_cnt;
  logic           dir_rx;
  logic           tick;
  logic           accept;
  logic           shift_en;
  logic [W-1:0]   sh_q;

  assign busy_o = (state != ST_IDLE);
  assign accept = start_i && (state == ST_IDLE);
  // rx shifts at the end of the high phase; tx advances at the end of the low phase
  assign shift_en = tick && ((dir_rx && state == ST_HIGH) || (!dir_rx && state == ST_LOW));

  tws_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (state == ST_HIGH || state == ST_LOW),
    .tick (tick)
  );

  tws_shift_reg #(.W(W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (dir_rx_i ? '0 : tx_byte_i),
    .shift    (shift_en),
    .shift_in (dir_rx ? sda_i : 1'b0),
    .q        (sh_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      dir_rx    <= 1'b0;
      scl_o     <= 1'b1;
      sda_o     <= 1'b0;
      sda_oe_o  <= 1'b0;
      done_o    <= 1'b0;
      rx_byte_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start_i) begin
          dir_rx  <= dir_rx_i;
          bit_cnt <= '0;
          if (dir_rx_i) state <= ST_HIGH;
          else begin
            sda_o <= tx_byte_i[W-1];
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          sda_oe_o <= 1'b1;
          state    <= ST_HIGH;
        end
        ST_HIGH: if (tick) begin
          scl_o <= 1'b0;
          state <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          scl_o <= 1'b1;
          if (bit_cnt == LAST_BIT) state <= ST_END;
          else begin
            bit_cnt <= bit_cnt + 1'b1;
            if (!dir_rx) sda_o <= sh_q[W-2];
            state <= ST_HIGH;
          end
        end
        ST_END: begin
          sda_oe_o <= 1'b0;
          done_o   <= 1'b1;
          if (dir_rx) rx_byte_o <= {{(W-KEEP_W){1'b0}}, sh_q[KEEP_W-1:0]};
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_scl_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> scl_o);

  p_data_before_oe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> ($stable(sda_o) && !dir_rx));

  p_rx_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && dir_rx) |-> !sda_oe_o);

  p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!sda_oe_o && scl_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_busy_after_start_r10: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: tb/tws_shifter_bench.sv
module tws_shifter_bench;
  localparam int H = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       dir_rx_i = 1'b0;
  logic [7:0] tx_byte_i = '0;
  logic       sda_i;
  logic       busy_o, done_o, scl_o, sda_o, sda_oe_o;
  logic [7:0] rx_byte_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] rx_pat = '0;
  logic [2:0] rx_idx = '0;
  logic [7:0] tx_cap = '0;
  int falls = 0, low_len = 0, high_len = 0;
  bit seen_rise = 0, prev_scl = 1, prev_busy = 0, mon_rx = 0;

  assign sda_i = rx_pat[3'd7 - rx_idx];

  always #4 clk = ~clk;

  tws_shifter #(.HALF_CYCLES(H)) u_tws_shifter (
    .clk(clk), .rst(rst), .start_i(start_i), .dir_rx_i(dir_rx_i),
    .tx_byte_i(tx_byte_i), .sda_i(sda_i), .busy_o(busy_o), .done_o(done_o),
    .rx_byte_o(rx_byte_o), .scl_o(scl_o), .sda_o(sda_o), .sda_oe_o(sda_oe_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rx(input logic [7:0] p);
    return p & 8'h0F;
  endfunction

  // link monitor and target model
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o && !prev_busy) begin
        falls = 0; seen_rise = 0; rx_idx = '0; tx_cap = '0;
      end
      if (prev_scl && !scl_o) begin
        if (seen_rise) chk(high_len == H, "R3 high phase", high_len, H);
        if (mon_rx) chk(!sda_oe_o, "R5 rx drive", sda_oe_o, 0);
        else begin
          chk(sda_oe_o, "R4 oe at fall", sda_oe_o, 1);
          tx_cap = {tx_cap[6:0], sda_o};
        end
        falls++;
        low_len = 1;
      end else if (!prev_scl && scl_o) begin
        chk(low_len == H, "R3 low phase", low_len, H);
        seen_rise = 1;
        high_len = 1;
        rx_idx = rx_idx + 1'b1;
      end else if (!scl_o) low_len++;
      else high_len++;
      prev_scl = scl_o;
      prev_busy = busy_o;
    end
  end

  task automatic run_byte(input logic [7:0] b, input bit rx, input bit inject);
    bit got;
    mon_rx = rx;
    if (rx) rx_pat = b;
    @(negedge clk);
    start_i = 1; dir_rx_i = rx; tx_byte_i = b;
    @(negedge clk);
    start_i = 0;
    chk(busy_o, "R10 busy after start", busy_o, 1);
    if (!rx) begin
      chk(!sda_oe_o && sda_o == b[7], "R4 data before oe", {sda_oe_o, sda_o}, {1'b0, b[7]});
      @(negedge clk);
      chk(sda_oe_o && sda_o == b[7], "R4 oe rises", {sda_oe_o, sda_o}, {1'b1, b[7]});
    end
    if (inject) begin
      repeat (20) @(negedge clk);
      start_i = 1; dir_rx_i = ~rx; tx_byte_i = ~b;
      @(negedge clk);
      start_i = 0;
    end
    got = 0;
    for (int i = 0; i < 2000 && !got; i++) begin
      if (done_o) got = 1;
      else @(negedge clk);
    end
    chk(got, "R8 done seen", got, 1);
    chk(!sda_oe_o && scl_o, "R6 line at done", {sda_oe_o, scl_o}, 2'b01);
    chk(!busy_o, "R10 busy drops", busy_o, 0);
    chk(falls == 8, "R1 bit count", falls, 8);
    if (rx) chk(rx_byte_o == exp_rx(b), "R7 rx data", rx_byte_o, exp_rx(b));
    else    chk(tx_cap == b, "R1 tx order", tx_cap, b);
    @(negedge clk);
    chk(!done_o, "R8 done width", done_o, 0);
    if (inject) begin
      got = 0;
      for (int i = 0; i < 30; i++) begin
        if (busy_o || done_o) got = 1;
        @(negedge clk);
      end
      chk(!got, "R9 start while busy ignored", got, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(scl_o && !sda_oe_o && !busy_o && !done_o, "R2 reset state",
        {scl_o, sda_oe_o, busy_o, done_o}, 4'b1000);
    run_byte(8'h80, 0, 0);
    run_byte(8'h01, 0, 0);
    run_byte(8'hA5, 1, 0);
    run_byte(8'hF0, 1, 0);
    run_byte(8'h3C, 0, 1);
    run_byte(8'h96, 1, 1);
    for (int n = 0; n < 24; n++) begin
      logic [7:0] b;
      b = 8'($urandom);
      run_byte(b, n[0], 0);
      repeat (n % 3) @(negedge clk);
      chk(scl_o && !busy_o, "R2 idle high", {scl_o, busy_o}, 2'b10);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule